// File: doc/BRIEF.md
# Per-Context Interrupt Priority Selector

This block is the arbitration core of a platform-level interrupt controller. It is purely combinational. For every interrupt context it takes the pending and claimed state of all sources, that context's enable mask, the priority of every source and the context's threshold. From these it produces the identifier of the source the context should see next, along with a request line. The register interface that stores these values and carries out claim and completion sits beside this block and feeds it directly.

Each context is bound at elaboration time to one hart and to one privilege level. The context's request is folded into that hart's machine-level or supervisor-level external interrupt line. A context bound to any other privilege code never raises a request. Because the selector holds no state, a change on any input, such as a claim landing, is visible on the outputs within the same cycle.

Top module: `irqsel_top`

## Requirements
- R1: A source competes for context c only when its pending bit is 1, its claimed bit is 0 and context c's enable bit for that source is 1. Clearing any one of these three conditions removes the source from the competition.
- R2: A competing source can be presented only when its priority is strictly greater than the context's threshold. A priority equal to the threshold is never presented.
- R3: Of the competing sources above the threshold, the one with the highest priority is presented.
- R4: When several competing sources share the highest priority, the one with the lowest source number is presented.
- R5: `ctx_id` for a context is 0 when nothing qualifies. `ctx_req[c]` is 1 exactly when that context's identifier is nonzero. With all inputs at 0, every identifier, request and hart line is 0.
- R6: Source n's pending and claimed bits are at bit n of their vectors, which means word n/32, bit n mod 32. Context c's enable bit for source n is at `ctx_enable[c*NWORD*32 + n]`. Source n's priority is at `src_prio[n*PRIO_W +: PRIO_W]`, context c's threshold at `ctx_thr[c*PRIO_W +: PRIO_W]`, and its identifier at `ctx_id[c*ID_W +: ID_W]`. Bits for source numbers at or above NSRC are ignored.
- R7: Source 0 is never presented, whatever its pending, enable or priority state.
- R8: Privilege code 2'b11 means machine and 2'b01 means supervisor. `hart_mext[h]` is the OR of the requests of machine contexts bound to hart h, and `hart_sext[h]` is the same for supervisor contexts. A context bound to any other code drives its request and identifier to 0. The default binding is: ctx0 hart0 machine, ctx1 hart0 supervisor, ctx2 hart1 machine, ctx3 hart1 supervisor, ctx4 hart1 code 2'b00.
- R9: The outputs follow the inputs with no clock edge in between. Once a claim removes the presented source, the request or identifier changes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_pending | input | NWORD*32 | Pending bit per source, word packed |
| src_claimed | input | NWORD*32 | Claimed (in service) bit per source |
| ctx_enable | input | NCTX*NWORD*32 | Enable masks, NWORD consecutive words per context |
| src_prio | input | NSRC*PRIO_W | Priority per source |
| ctx_thr | input | NCTX*PRIO_W | Threshold per context |
| ctx_id | output | NCTX*ID_W | Presented source identifier per context, 0 for none |
| ctx_req | output | NCTX | Request per context |
| hart_mext | output | NHART | Machine-level external interrupt per hart |
| hart_sext | output | NHART | Supervisor-level external interrupt per hart |

## Verification
The block has no state, so a fault in the comparison tree or in the candidate gating cannot stay hidden. It shows up at once as a wrong identifier or a wrong request on the context whose inputs exposed it. A reversed tie rule only shows up when equal priorities compete, and a threshold check that uses the wrong sense only shows up when a priority equals the threshold. The stimulus therefore uses a narrow priority range that produces many ties and many cases at the threshold. A routing fault is visible on the hart lines of the affected hart only, in the same cycle as the context request.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned HART_F_W = 8;

    typedef enum logic [1:0] {
        PM_USER = 2'b00,
        PM_SUPV = 2'b01,
        PM_RSVD = 2'b10,
        PM_MACH = 2'b11
    } priv_mode_e;

    function automatic int unsigned words_for(input int unsigned nsrc);
        return (nsrc + WORD_W - 1) / WORD_W;
    endfunction

    function automatic logic mode_routed(input logic [1:0] code);
        return (code == PM_MACH) || (code == PM_SUPV);
    endfunction

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
    import irqsel_pkg::*;
#(
    parameter int unsigned NSRC  = 40,
    parameter int unsigned NWORD = 2,
    localparam int unsigned TOT  = NWORD * WORD_W
) (
    input  logic [TOT-1:0]  pending_words,
    input  logic [TOT-1:0]  claimed_words,
    input  logic [TOT-1:0]  enable_words,
    output logic [NSRC-1:0] cand
);

    // source 0 is reserved and never competes
    assign cand[0] = 1'b0;

    for (genvar n = 1; n < NSRC; n++) begin : g_src
        assign cand[n] = pending_words[n] & ~claimed_words[n] & enable_words[n];
    end

    if (TOT > NSRC) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^{pending_words[TOT-1:NSRC], claimed_words[TOT-1:NSRC],
                              enable_words[TOT-1:NSRC], pending_words[0],
                              claimed_words[0], enable_words[0]};
    end else begin : g_nopad
        logic unused_zero;
        assign unused_zero = ^{pending_words[0], claimed_words[0], enable_words[0]};
    end

endmodule

// File: rtl/irqsel_tree.sv
module irqsel_tree
    import irqsel_pkg::*;
#(
    parameter int unsigned NSRC   = 40,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned LVL   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int unsigned ID_W  = LVL,
    localparam int unsigned NLEAF = 1 << LVL
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]      thr,
    output logic                   win_valid,
    output logic [ID_W-1:0]        win_id
);

    typedef struct packed {
        logic              v;
        logic [PRIO_W-1:0] p;
        logic [ID_W-1:0]   i;
    } node_t;

    // the right (higher numbered) child wins only on strictly greater priority
    function automatic node_t pick(input node_t lo, input node_t hi);
        if (hi.v && (!lo.v || (hi.p > lo.p)))
            return hi;
        return lo;
    endfunction

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int unsigned W = NLEAF >> l;
        node_t nd [W];
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < NLEAF; k++) begin : g_k
                if (k < NSRC) begin : g_real
                    assign nd[k].v = cand[k] && (prio_flat[k*PRIO_W +: PRIO_W] > thr);
                    assign nd[k].p = prio_flat[k*PRIO_W +: PRIO_W];
                    assign nd[k].i = ID_W'(k);
                end else begin : g_fill
                    assign nd[k] = '0;
                end
            end
        end else begin : g_join
            for (genvar k = 0; k < W; k++) begin : g_k
                assign nd[k] = pick(g_lvl[l-1].nd[2*k], g_lvl[l-1].nd[2*k+1]);
            end
        end
    end

    node_t root;
    assign root      = g_lvl[LVL].nd[0];
    assign win_valid = root.v;
    assign win_id    = root.i;

    always_comb begin : tree_checks
        if (root.v) begin
            // R2
            thr_clear_chk: assert (prio_flat[root.i*PRIO_W +: PRIO_W] > thr)
                else $error("winner not above threshold");
        end
        for (int n = 1; n < NSRC; n++) begin
            if (cand[n] && (prio_flat[n*PRIO_W +: PRIO_W] > thr)) begin
                // R3 R4
                best_pick_chk: assert (root.v &&
                    ((prio_flat[n*PRIO_W +: PRIO_W] < root.p) ||
                     ((prio_flat[n*PRIO_W +: PRIO_W] == root.p) && (n >= int'(root.i)))))
                    else $error("better candidate %0d not chosen", n);
            end
        end
    end

endmodule

// File: rtl/irqsel_route.sv
module irqsel_route
    import irqsel_pkg::*;
#(
    parameter int unsigned NCTX  = 5,
    parameter int unsigned NHART = 2,
    parameter logic [NCTX*HART_F_W-1:0] CTX_HART = '0,
    parameter logic [NCTX*2-1:0]        CTX_MODE = '0
) (
    input  logic [NCTX-1:0]  req,
    output logic [NHART-1:0] mext,
    output logic [NHART-1:0] sext
);

    always_comb begin
        mext = '0;
        sext = '0;
        for (int h = 0; h < NHART; h++) begin
            for (int c = 0; c < NCTX; c++) begin
                if (CTX_HART[c*HART_F_W +: HART_F_W] == HART_F_W'(h)) begin
                    if (CTX_MODE[c*2 +: 2] == PM_MACH) mext[h] = mext[h] | req[c];
                    if (CTX_MODE[c*2 +: 2] == PM_SUPV) sext[h] = sext[h] | req[c];
                end
            end
        end
    end

    always_comb begin : route_checks
        for (int c = 0; c < NCTX; c++) begin
            if (req[c] && (int'(CTX_HART[c*HART_F_W +: HART_F_W]) < NHART)) begin
                // R8
                route_hit_chk: assert (
                    (CTX_MODE[c*2 +: 2] == PM_MACH) ? mext[CTX_HART[c*HART_F_W +: HART_F_W]] :
                                                      sext[CTX_HART[c*HART_F_W +: HART_F_W]])
                    else $error("context %0d request not routed", c);
            end
        end
    end

endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int unsigned NSRC   = 40,
    parameter int unsigned NCTX   = 5,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned NHART  = 2,
    parameter logic [NCTX*HART_F_W-1:0] CTX_HART = {8'd1, 8'd1, 8'd1, 8'd0, 8'd0},
    parameter logic [NCTX*2-1:0]        CTX_MODE = {2'b00, 2'b01, 2'b11, 2'b01, 2'b11},
    localparam int unsigned NWORD = words_for(NSRC),
    localparam int unsigned TOT   = NWORD * WORD_W,
    localparam int unsigned ID_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [TOT-1:0]         src_pending,
    input  logic [TOT-1:0]         src_claimed,
    input  logic [NCTX*TOT-1:0]    ctx_enable,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [NCTX*PRIO_W-1:0] ctx_thr,
    output logic [NCTX*ID_W-1:0]   ctx_id,
    output logic [NCTX-1:0]        ctx_req,
    output logic [NHART-1:0]       hart_mext,
    output logic [NHART-1:0]       hart_sext
);

    logic [NCTX-1:0] req_c;

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        localparam logic [1:0] MODE = CTX_MODE[c*2 +: 2];
        logic [NSRC-1:0] cand;
        logic            wv;
        logic [ID_W-1:0] wi;

        irqsel_gate #(.NSRC(NSRC), .NWORD(NWORD)) u_gate (
            .pending_words (src_pending),
            .claimed_words (src_claimed),
            .enable_words  (ctx_enable[c*TOT +: TOT]),
            .cand          (cand)
        );

        irqsel_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_tree (
            .cand      (cand),
            .prio_flat (src_prio),
            .thr       (ctx_thr[c*PRIO_W +: PRIO_W]),
            .win_valid (wv),
            .win_id    (wi)
        );

        assign req_c[c] = wv && mode_routed(MODE);
        assign ctx_id[c*ID_W +: ID_W] = req_c[c] ? wi : '0;

        always_comb begin : ctx_checks
            if (req_c[c]) begin
                // R7
                no_src_zero_chk: assert (ctx_id[c*ID_W +: ID_W] != '0)
                    else $error("context %0d presents source 0", c);
                // R1
                cand_ok_chk: assert (src_pending[wi] && !src_claimed[wi] &&
                                     ctx_enable[c*TOT + int'(wi)])
                    else $error("context %0d presents a non-candidate", c);
            end
        end
    end

    assign ctx_req = req_c;

    irqsel_route #(
        .NCTX(NCTX), .NHART(NHART), .CTX_HART(CTX_HART), .CTX_MODE(CTX_MODE)
    ) u_route (
        .req  (req_c),
        .mext (hart_mext),
        .sext (hart_sext)
    );

endmodule

// File: tb/irqsel_top_tb.sv
module irqsel_top_tb_top;

    localparam int NSRC = 40;
    localparam int NCTX = 5;
    localparam int PW   = 3;
    localparam int NH   = 2;
    localparam int NW   = 2;
    localparam int TOT  = NW * 32;
    localparam int IDW  = 6;
    localparam logic [NCTX*8-1:0] HART_MAP = {8'd1, 8'd1, 8'd1, 8'd0, 8'd0};
    localparam logic [NCTX*2-1:0] MODE_MAP = {2'b00, 2'b01, 2'b11, 2'b01, 2'b11};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [TOT-1:0]       pend, clm;
    logic [NCTX*TOT-1:0]  en;
    logic [NSRC*PW-1:0]   prio;
    logic [NCTX*PW-1:0]   thr;
    logic [NCTX*IDW-1:0]  id;
    logic [NCTX-1:0]      req;
    logic [NH-1:0]        mext, sext;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    irqsel_top #(
        .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PW), .NHART(NH),
        .CTX_HART(HART_MAP), .CTX_MODE(MODE_MAP)
    ) dut_i (
        .src_pending(pend), .src_claimed(clm), .ctx_enable(en),
        .src_prio(prio), .ctx_thr(thr),
        .ctx_id(id), .ctx_req(req), .hart_mext(mext), .hart_sext(sext)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_id(input int c);
        int best = int'(thr[c*PW +: PW]);
        int win  = 0;
        if (!(MODE_MAP[c*2 +: 2] == 2'b11 || MODE_MAP[c*2 +: 2] == 2'b01)) return 0;
        for (int n = 1; n < NSRC; n++) begin
            if (pend[n] && !clm[n] && en[c*TOT + n] && int'(prio[n*PW +: PW]) > best) begin
                best = int'(prio[n*PW +: PW]);
                win  = n;
            end
        end
        return win;
    endfunction

    task automatic check_model(input string tag);
        int ev [NCTX];
        int em, es;
        for (int c = 0; c < NCTX; c++) begin
            ev[c] = exp_id(c);
            chk(tag, $sformatf("id ctx%0d", c), int'(id[c*IDW +: IDW]), ev[c]);
            chk("R5", $sformatf("req ctx%0d", c), int'(req[c]), int'(ev[c] != 0));
        end
        for (int h = 0; h < NH; h++) begin
            em = 0; es = 0;
            for (int c = 0; c < NCTX; c++) begin
                if (int'(HART_MAP[c*8 +: 8]) == h && ev[c] != 0) begin
                    if (MODE_MAP[c*2 +: 2] == 2'b11) em = 1;
                    if (MODE_MAP[c*2 +: 2] == 2'b01) es = 1;
                end
            end
            chk("R8", $sformatf("mext h%0d", h), int'(mext[h]), em);
            chk("R8", $sformatf("sext h%0d", h), int'(sext[h]), es);
        end
    endtask

    task automatic clear_all();
        pend = '0; clm = '0; en = '0; prio = '0; thr = '0;
    endtask

    function automatic int idc(input int c);
        return int'(id[c*IDW +: IDW]);
    endfunction

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        clear_all();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        settle();

        // R5: all-zero inputs
        for (int c = 0; c < NCTX; c++) chk("R5", "idle id", idc(c), 0);
        chk("R5", "idle req", int'(req), 0);
        chk("R5", "idle harts", int'({mext, sext}), 0);

        // R1: candidate gating
        prio[5*PW +: PW] = 3'd3; en[0*TOT + 5] = 1'b1; pend[5] = 1'b1; clm[5] = 1'b1;
        settle(); chk("R1", "claimed src5", idc(0), 0);
        clm[5] = 1'b0;
        settle(); chk("R1", "cand src5", idc(0), 5);
        en[0*TOT + 5] = 1'b0;
        settle(); chk("R1", "disabled src5", idc(0), 0);
        en[0*TOT + 5] = 1'b1; pend[5] = 1'b0;
        settle(); chk("R1", "not pending src5", idc(0), 0);
        pend[5] = 1'b1;

        // R2: strict threshold
        thr[0*PW +: PW] = 3'd3;
        settle(); chk("R2", "prio eq thr", idc(0), 0);
        chk("R2", "req at eq", int'(req[0]), 0);
        prio[5*PW +: PW] = 3'd4;
        settle(); chk("R2", "prio above thr", idc(0), 5);

        // R3: higher priority wins
        prio[7*PW +: PW] = 3'd6; en[0*TOT + 7] = 1'b1; pend[7] = 1'b1;
        settle(); chk("R3", "higher src7", idc(0), 7);

        // R9: claim removes winner with no clock edge
        @(negedge clk);
        clm[7] = 1'b1;
        #1; chk("R9", "after claim", idc(0), 5);
        chk("R9", "hart0 m line", int'(mext[0]), 1);

        // R4: ties
        clear_all();
        prio[9*PW +: PW] = 3'd5; prio[20*PW +: PW] = 3'd5;
        pend[9] = 1'b1; pend[20] = 1'b1; en[1*TOT + 9] = 1'b1; en[1*TOT + 20] = 1'b1;
        settle(); chk("R4", "tie 9 vs 20", idc(1), 9);
        prio[33*PW +: PW] = 3'd7; prio[38*PW +: PW] = 3'd7;
        pend[33] = 1'b1; pend[38] = 1'b1; en[1*TOT + 33] = 1'b1; en[1*TOT + 38] = 1'b1;
        settle(); chk("R4", "tie 33 vs 38", idc(1), 33);
        chk("R8", "sext hart0", int'(sext[0]), 1);

        // R7: source 0 reserved
        clear_all();
        prio[0 +: PW] = 3'd7; pend[0] = 1'b1; en[2*TOT + 0] = 1'b1;
        settle(); chk("R7", "src0 alone", idc(2), 0);
        chk("R7", "src0 req", int'(req[2]), 0);

        // R6: packing across word boundary, pad bits ignored
        clear_all();
        prio[33*PW +: PW] = 3'd2; pend[33] = 1'b1; en[2*TOT + 33] = 1'b1;
        pend[41] = 1'b1; en[2*TOT + 41] = 1'b1; en[3*TOT + 41] = 1'b1;
        settle(); chk("R6", "word1 bit1", idc(2), 33);
        chk("R6", "pad ignored ctx3", idc(3), 0);
        chk("R8", "mext hart1", int'(mext[1]), 1);
        chk("R8", "mext hart0", int'(mext[0]), 0);

        // R8: unsupported privilege code
        clear_all();
        prio[5*PW +: PW] = 3'd4; pend[5] = 1'b1; en[4*TOT + 5] = 1'b1;
        settle(); chk("R8", "user ctx4 id", idc(4), 0);
        chk("R8", "user ctx4 req", int'(req[4]), 0);
        chk("R8", "hart lines", int'({mext, sext}), 0);

        // R3: random mix with narrow priorities
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            for (int w = 0; w < NW; w++) begin
                pend[w*32 +: 32] = $urandom() & $urandom();
                clm[w*32 +: 32]  = $urandom() & $urandom() & $urandom();
            end
            for (int k = 0; k < NCTX * NW; k++) en[k*32 +: 32] = $urandom();
            for (int n = 0; n < NSRC; n++) prio[n*PW +: PW] = PW'($urandom_range(0, 7));
            for (int c = 0; c < NCTX; c++) thr[c*PW +: PW] = PW'($urandom_range(0, 4));
            #1;
            check_model("R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule